// File: doc/BRIEF.md
# Shift-and-Logic Datapath Stage with Condition Flags

This combinational stage sits in the execute path of a register-based processor. It passes its second operand through a barrel shifter (logical left, logical right, arithmetic right, rotate right, or a one-bit rotate through the carry) and then merges the shifted value with the first operand using one of several bitwise operations. In the same pass it works out the next negative, zero and carry flags, and it decides whether the outcome is written to a general register, steered to the program counter, or dropped.

The shift amount is an 8-bit value. It may come from an immediate field or from the low byte of a register, so it can range from 0 to 255. Every amount in that range has a defined result. The carry produced by the shifter becomes the new C flag. The caller supplies the current N, Z and C flags, and the stage returns them unchanged when no flag update is due.

Top module: `shl_unit`

## Requirements
- R1: Shift kind code 0 (left logical) by an amount n from 1 to 31 gives operand B shifted left, with carry equal to B[32-n]. For n = 32 the result is 0 and the carry is B[0]. For n above 32 both the result and the carry are 0.
- R2: Shift kind code 1 (right logical) by n from 1 to 31 zero-fills and gives carry B[n-1]. For n = 32 the result is 0 and the carry is B[31]. For n above 32 both are 0.
- R3: Shift kind code 2 (right arithmetic) by n from 1 to 31 fills with B[31] and gives carry B[n-1]. For n of 32 or more, every result bit and the carry equal B[31].
- R4: Shift kind code 3 (rotate right) rotates by n mod 32, and the carry is bit 31 of the rotated value. A non-zero multiple of 32 leaves B unchanged, with carry B[31].
- R5: Shift kind code 4 (rotate through carry) ignores the amount. The result is {c_in, B[31:1]} and the carry is B[0].
- R6: For shift kind codes 0 to 3, an amount of 0 passes B through unchanged, and the shifter carry equals c_in.
- R7: With sh the shifted value, operation codes give: 0 A&sh, 1 A|sh, 2 A&~sh, 3 A|~sh, 4 sh (move), 5 ~sh (move inverted), 6 A&sh (test). Codes 4 and 5 ignore A.
- R8: When flags are updated, N is result bit 31, Z is 1 exactly when the result is zero, and C is the shifter carry.
- R9: When cond_ok is high, flag_en is low and the operation is not test, the N, Z and C outputs equal n_in, z_in and c_in.
- R10: The test operation (code 6) always updates all three flags and asserts neither reg_we nor pc_we.
- R11: For move operations (codes 4 and 5) with dst_idx = 15, pc_we is 1 and reg_we is 0. Every other passing non-test operation asserts reg_we and not pc_we.
- R12: When cond_ok is low, reg_we and pc_we are 0 and the flags equal their inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 32 | First operand A |
| opb | input | 32 | Operand B, fed to the shifter |
| sh_kind | input | 3 | Shift kind code |
| sh_amt | input | 8 | Shift amount, 0 to 255 |
| c_in | input | 1 | Current carry flag |
| n_in | input | 1 | Current negative flag |
| z_in | input | 1 | Current zero flag |
| op_sel | input | 3 | Logical operation code |
| flag_en | input | 1 | Request a flag update |
| cond_ok | input | 1 | Condition check passed |
| dst_idx | input | 4 | Destination register index |
| res | output | 32 | Operation result |
| reg_we | output | 1 | Register write enable |
| pc_we | output | 1 | Program counter write strobe |
| n_nx | output | 1 | Next negative flag |
| z_nx | output | 1 | Next zero flag |
| c_nx | output | 1 | Next carry flag |

## Verification
The boundary amounts are the hardest cases to reach: exactly 32, just above it, large multiples of 32 for the rotate, and zero. The bit that becomes the carry changes at each of these points, and random 8-bit amounts seldom hit them. The stimulus therefore sweeps every shift kind across a fixed list of amounts (0, 1, 31, 32, 33, 64, 96, 200, 255) with several operand patterns and both carry values. It then adds a large random pass in which the amount is drawn from that list half of the time.

// File: rtl/shl_pkg.sv
package shl_pkg;
   typedef enum logic [2:0] {
      SK_LSL = 3'd0,
      SK_LSR = 3'd1,
      SK_ASR = 3'd2,
      SK_ROR = 3'd3,
      SK_RRX = 3'd4
   } shift_kind_e;

   typedef enum logic [2:0] {
      OP_AND = 3'd0,
      OP_ORR = 3'd1,
      OP_BIC = 3'd2,
      OP_ORN = 3'd3,
      OP_MOV = 3'd4,
      OP_MVN = 3'd5,
      OP_TST = 3'd6
   } logic_op_e;
endpackage

// File: rtl/shl_barrel.sv
module shl_barrel #(
   parameter int DW = 32,
   parameter int AW = 8
) (
   input  logic [DW-1:0] val,
   input  logic [2:0]    kind,
   input  logic [AW-1:0] amt,
   input  logic          cin,
   output logic [DW-1:0] out,
   output logic          cout
);
   import shl_pkg::*;
   localparam int RW = $clog2(DW);

   logic [DW:0]        lsl_ext;
   logic [DW:0]        lsr_ext;
   logic signed [DW:0] asr_ext;
   logic [RW-1:0]      rot_n;
   logic [DW-1:0]      rot_v;
   logic               amt_zero;

   assign amt_zero = (amt == '0);
   assign lsl_ext  = {1'b0, val} << amt;
   assign lsr_ext  = {val, 1'b0} >> amt;
   assign asr_ext  = $signed({val, 1'b0}) >>> amt;
   assign rot_n    = amt[RW-1:0];
   assign rot_v    = (val >> rot_n) | (val << (DW - int'(rot_n)));

   always_comb begin
      out  = val;
      cout = cin;
      case (kind)
         SK_LSL: if (!amt_zero) begin
            out  = lsl_ext[DW-1:0];
            cout = lsl_ext[DW];
         end
         SK_LSR: if (!amt_zero) begin
            out  = lsr_ext[DW:1];
            cout = lsr_ext[0];
         end
         SK_ASR: if (!amt_zero) begin
            out  = asr_ext[DW:1];
            cout = asr_ext[0];
         end
         SK_ROR: if (!amt_zero) begin
            out  = rot_v;
            cout = rot_v[DW-1];
         end
         SK_RRX: begin
            out  = {cin, val[DW-1:1]};
            cout = val[0];
         end
         default: begin
            out  = val;
            cout = cin;
         end
      endcase
   end
endmodule

// File: rtl/shl_logic.sv
module shl_logic #(
   parameter int DW = 32
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] sh,
   input  logic [2:0]    op,
   output logic [DW-1:0] y
);
   import shl_pkg::*;

   for (genvar i = 0; i < DW; i++) begin : g_bit
      always_comb begin
         case (op)
            OP_AND, OP_TST: y[i] = a[i] & sh[i];
            OP_ORR:         y[i] = a[i] | sh[i];
            OP_BIC:         y[i] = a[i] & ~sh[i];
            OP_ORN:         y[i] = a[i] | ~sh[i];
            OP_MVN:         y[i] = ~sh[i];
            default:        y[i] = sh[i];
         endcase
      end
   end
endmodule

// File: rtl/shl_flags.sv
module shl_flags #(
   parameter int DW     = 32,
   parameter int IW     = 4,
   parameter int PC_IDX = 15
) (
   input  logic [DW-1:0] y,
   input  logic          sh_c,
   input  logic [2:0]    op,
   input  logic          flag_en,
   input  logic          cond_ok,
   input  logic [IW-1:0] dst,
   input  logic          n_in,
   input  logic          z_in,
   input  logic          c_in,
   output logic          reg_we,
   output logic          pc_we,
   output logic          n_nx,
   output logic          z_nx,
   output logic          c_nx
);
   import shl_pkg::*;

   logic is_test, is_move, to_pc, upd;

   assign is_test = (op == OP_TST);
   assign is_move = (op == OP_MOV) || (op == OP_MVN);
   assign to_pc   = is_move && (dst == IW'(PC_IDX));
   assign upd     = cond_ok && (flag_en || is_test);

   assign reg_we  = cond_ok && !is_test && !to_pc;
   assign pc_we   = cond_ok && to_pc;

   assign n_nx = upd ? y[DW-1]   : n_in;
   assign z_nx = upd ? (y == '0) : z_in;
   assign c_nx = upd ? sh_c      : c_in;
endmodule

// File: rtl/shl_unit.sv
module shl_unit #(
   parameter int DW     = 32,
   parameter int AW     = 8,
   parameter int IW     = 4,
   parameter int PC_IDX = 15
) (
   input  logic [DW-1:0] opa,
   input  logic [DW-1:0] opb,
   input  logic [2:0]    sh_kind,
   input  logic [AW-1:0] sh_amt,
   input  logic          c_in,
   input  logic          n_in,
   input  logic          z_in,
   input  logic [2:0]    op_sel,
   input  logic          flag_en,
   input  logic          cond_ok,
   input  logic [IW-1:0] dst_idx,
   output logic [DW-1:0] res,
   output logic          reg_we,
   output logic          pc_we,
   output logic          n_nx,
   output logic          z_nx,
   output logic          c_nx
);
   localparam int RW = $clog2(DW);

   if ((1 << RW) != DW || DW < 2) begin : g_bad_dw
      $error("shl_unit: DW must be a power of two, at least 2");
   end
   if ((1 << AW) <= DW) begin : g_bad_aw
      $error("shl_unit: AW must reach amounts beyond DW");
   end
   if (PC_IDX >= (1 << IW) || PC_IDX < 0) begin : g_bad_pc
      $error("shl_unit: PC_IDX out of index range");
   end

   logic [DW-1:0] sh_val;
   logic          sh_c;

   shl_barrel #(.DW(DW), .AW(AW)) u_barrel (
      .val(opb), .kind(sh_kind), .amt(sh_amt), .cin(c_in),
      .out(sh_val), .cout(sh_c)
   );

   shl_logic #(.DW(DW)) u_logic (
      .a(opa), .sh(sh_val), .op(op_sel), .y(res)
   );

   shl_flags #(.DW(DW), .IW(IW), .PC_IDX(PC_IDX)) u_flags (
      .y(res), .sh_c(sh_c), .op(op_sel), .flag_en(flag_en),
      .cond_ok(cond_ok), .dst(dst_idx), .n_in(n_in), .z_in(z_in),
      .c_in(c_in), .reg_we(reg_we), .pc_we(pc_we),
      .n_nx(n_nx), .z_nx(z_nx), .c_nx(c_nx)
   );
endmodule

// File: rtl/shl_unit_chk.sv
module shl_unit_chk #(
   parameter int DW     = 32,
   parameter int AW     = 8,
   parameter int IW     = 4,
   parameter int PC_IDX = 15
) (
   input logic [DW-1:0] opb,
   input logic [2:0]    sh_kind,
   input logic [AW-1:0] sh_amt,
   input logic          c_in,
   input logic          n_in,
   input logic          z_in,
   input logic [2:0]    op_sel,
   input logic          flag_en,
   input logic          cond_ok,
   input logic [IW-1:0] dst_idx,
   input logic [DW-1:0] res,
   input logic          reg_we,
   input logic          pc_we,
   input logic          n_nx,
   input logic          z_nx,
   input logic          c_nx
);
   logic updating;
   assign updating = cond_ok && (flag_en || op_sel == 3'd6);

   always_comb begin
      // R12
      cond_fail_quiet_chk: assert (cond_ok || (!reg_we && !pc_we &&
         n_nx == n_in && z_nx == z_in && c_nx == c_in));
      // R11
      write_exclusive_chk: assert (!(reg_we && pc_we));
      // R11
      pc_only_move15_chk: assert (!pc_we ||
         ((op_sel == 3'd4 || op_sel == 3'd5) && dst_idx == IW'(PC_IDX)));
      // R10
      test_no_write_chk: assert (op_sel != 3'd6 || (!reg_we && !pc_we));
      // R9
      flags_hold_chk: assert (!(cond_ok && !updating) ||
         (n_nx == n_in && z_nx == z_in && c_nx == c_in));
      // R8
      flags_match_res_chk: assert (!updating ||
         (n_nx == res[DW-1] && z_nx == (res == '0)));
      // R6
      zero_amt_pass_chk: assert (!(sh_amt == '0 && sh_kind <= 3'd3 &&
         op_sel == 3'd4) || (res == opb && (!updating || c_nx == c_in)));
   end
endmodule

bind shl_unit shl_unit_chk #(.DW(DW), .AW(AW), .IW(IW), .PC_IDX(PC_IDX)) u_chk (
   .opb(opb), .sh_kind(sh_kind), .sh_amt(sh_amt), .c_in(c_in),
   .n_in(n_in), .z_in(z_in), .op_sel(op_sel), .flag_en(flag_en),
   .cond_ok(cond_ok), .dst_idx(dst_idx), .res(res), .reg_we(reg_we),
   .pc_we(pc_we), .n_nx(n_nx), .z_nx(z_nx), .c_nx(c_nx)
);

// File: tb/tb_shl_unit.sv
`timescale 1ns/1ps
module tb_shl_unit;
   logic clk = 1'b0;
   logic rst = 1'b1;
   always #4 clk = ~clk;

   logic [31:0] opa, opb, res;
   logic [2:0]  sh_kind, op_sel;
   logic [7:0]  sh_amt;
   logic [3:0]  dst_idx;
   logic c_in, n_in, z_in, flag_en, cond_ok;
   logic reg_we, pc_we, n_nx, z_nx, c_nx;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 0;

   shl_unit dut (
      .opa(opa), .opb(opb), .sh_kind(sh_kind), .sh_amt(sh_amt),
      .c_in(c_in), .n_in(n_in), .z_in(z_in), .op_sel(op_sel),
      .flag_en(flag_en), .cond_ok(cond_ok), .dst_idx(dst_idx),
      .res(res), .reg_we(reg_we), .pc_we(pc_we),
      .n_nx(n_nx), .z_nx(z_nx), .c_nx(c_nx)
   );

   // Behavioural model, computed bit by bit from the requirements.
   function automatic void model(
      input logic [31:0] a, b, input int kind, input int amt, input bit cin,
      input int op, input bit fen, input bit cok, input int dst,
      input bit nin, input bit zin,
      output logic [31:0] r, output bit we, output bit pw,
      output bit n, output bit z, output bit c);
      logic [31:0] s;
      bit sc;
      int k;
      s = b; sc = cin;
      if (kind == 4) begin                       // R5
         s = {cin, b[31:1]}; sc = b[0];
      end else if (amt != 0) begin
         case (kind)
            0: begin                             // R1
               for (int i = 0; i < 32; i++) s[i] = (i >= amt) ? b[i-amt] : 1'b0;
               sc = (amt <= 32) ? b[32-amt] : 1'b0;
            end
            1: begin                             // R2
               for (int i = 0; i < 32; i++) s[i] = (i + amt < 32) ? b[i+amt] : 1'b0;
               sc = (amt <= 32) ? b[amt-1] : 1'b0;
            end
            2: begin                             // R3
               for (int i = 0; i < 32; i++) s[i] = (i + amt < 32) ? b[i+amt] : b[31];
               sc = (amt <= 32) ? b[amt-1] : b[31];
            end
            default: begin                       // R4
               k = amt % 32;
               for (int i = 0; i < 32; i++) s[i] = b[(i+k)%32];
               sc = s[31];
            end
         endcase
      end
      case (op)                                  // R7
         0, 6: r = a & s;
         1: r = a | s;
         2: r = a & ~s;
         3: r = a | ~s;
         5: r = ~s;
         default: r = s;
      endcase
      we = cok && op != 6 && !((op == 4 || op == 5) && dst == 15);
      pw = cok && (op == 4 || op == 5) && dst == 15;
      if (cok && (fen || op == 6)) begin
         n = r[31]; z = (r == 0); c = sc;
      end else begin
         n = nin; z = zin; c = cin;
      end
   endfunction

   function automatic string data_tag(int kind, int amt, int op, bit cok, bit fen, int dst);
      if (!cok) return "R12";
      if (op == 6) return "R10";
      if ((op == 4 || op == 5) && dst == 15) return "R11";
      if (kind == 4) return "R5";
      if (amt == 0 && kind < 4) return "R6";
      if (op != 4) return "R7";
      case (kind)
         0: return "R1";
         1: return "R2";
         2: return "R3";
         default: return "R4";
      endcase
   endfunction

   function automatic string flag_tag(int op, bit cok, bit fen);
      if (!cok) return "R12";
      if (op == 6) return "R10";
      if (!fen) return "R9";
      return "R8";
   endfunction

   task automatic apply(input logic [31:0] a, b, input int kind, input int amt,
                        input bit cin, input int op, input bit fen, input bit cok,
                        input int dst, input bit nin, input bit zin);
      logic [31:0] er;
      bit ew, ep, en, ez, ec;
      string t;
      @(posedge clk);
      opa = a; opb = b; sh_kind = 3'(kind); sh_amt = 8'(amt); c_in = cin;
      op_sel = 3'(op); flag_en = fen; cond_ok = cok; dst_idx = 4'(dst);
      n_in = nin; z_in = zin;
      @(negedge clk);
      model(a, b, kind, amt, cin, op, fen, cok, dst, nin, zin, er, ew, ep, en, ez, ec);
      t = data_tag(kind, amt, op, cok, fen, dst);
      checks++;
      if (res !== er || reg_we !== ew || pc_we !== ep) begin
         fails++;
         $display("FAIL %s: res=%h we=%b pc=%b expected res=%h we=%b pc=%b (kind=%0d amt=%0d op=%0d)",
                  t, res, reg_we, pc_we, er, ew, ep, kind, amt, op);
      end
      t = flag_tag(op, cok, fen);
      checks++;
      if (n_nx !== en || z_nx !== ez || c_nx !== ec) begin
         fails++;
         $display("FAIL %s: nzc=%b%b%b expected %b%b%b (kind=%0d amt=%0d op=%0d)",
                  t, n_nx, z_nx, c_nx, en, ez, ec, kind, amt, op);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         done = 1;
         fails++;
         $display("FAIL watchdog: cycles=%0d expected completion", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   int amts [9] = '{0, 1, 31, 32, 33, 64, 96, 200, 255};
   logic [31:0] pats [4] = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hA5C3_0F96, 32'h0000_0000};

   initial begin
      opa = '0; opb = '0; sh_kind = '0; sh_amt = '0; c_in = 0; n_in = 0; z_in = 0;
      op_sel = 3'd4; flag_en = 0; cond_ok = 0; dst_idx = '0;
      repeat (3) @(posedge clk);
      rst = 0;
      @(negedge clk);
      // Reset state, condition failed: R12
      checks++;
      if (reg_we !== 0 || pc_we !== 0 || res !== 0 || n_nx !== 0 || z_nx !== 0 || c_nx !== 0) begin
         fails++;
         $display("FAIL R12: idle we=%b pc=%b res=%h expected 0 0 0", reg_we, pc_we, res);
      end
      // Shift-kind sweep over boundary amounts: R1 R2 R3 R4 R5 R6 R8
      for (int k = 0; k < 5; k++)
         for (int ai = 0; ai < 9; ai++)
            for (int pi = 0; pi < 4; pi++)
               for (int c = 0; c < 2; c++)
                  apply(32'h0, pats[pi], k, amts[ai], bit'(c), 4, 1, 1, 3, 0, 0);
      // Operation sweep: R7 R10 R11 R9
      for (int op = 0; op < 7; op++)
         for (int d = 14; d < 16; d++)
            for (int f = 0; f < 2; f++)
               apply(32'hF0F0_1234, 32'h0FF0_8421, 0, 4, 1, op, bit'(f), 1, d, 1, 0);
      // Condition failed with every operation: R12
      for (int op = 0; op < 7; op++)
         apply(32'hFFFF_FFFF, 32'h1, 3, 1, 1, op, 1, 0, 15, 0, 1);
      // Random pass
      for (int n = 0; n < 4000; n++) begin
         int amt;
         amt = ($urandom_range(0, 1) == 0) ? amts[$urandom_range(0, 8)] : int'($urandom_range(0, 255));
         apply($urandom, ($urandom_range(0, 7) == 0) ? 32'h0 : $urandom,
               int'($urandom_range(0, 4)), amt, bit'($urandom_range(0, 1)),
               int'($urandom_range(0, 6)), bit'($urandom_range(0, 1)),
               ($urandom_range(0, 7) != 0), int'($urandom_range(0, 15)),
               bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
      end
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule